// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the front end of an I2C target. It watches the bus lines for START, repeated START and STOP conditions, shifts in the first byte of each transfer, and decides whether this device is being addressed. Three kinds of address can select it: a programmable 7-bit address, a programmable 10-bit address made of a header byte and a second byte, and the general-call address. When the address matches, the block pulls SDA low in the ninth clock. It then moves to a byte data path: in a write it presents each received byte with a one-cycle strobe and acknowledges it, and in a read it takes a byte from the host side and shifts it out MSB first.

The matched address kind and the transfer direction are reported on ports. Both are cleared at every START and every STOP. The direction is re-decided at each repeated START, so a write can be followed by a read without a STOP in between. SCL and SDA enter through a synchronizer. SDA is driven open-drain through `sdaOe`, where a 1 pulls the line low.

Top module: `i2c_am_top`

## Requirements
- R1: After reset, `sdaOe` is 0, `matchMode` is 0 (none), `readDir` is 0, and `rxValid` and `txTaken` are 0.
- R2: An address byte whose upper seven bits equal `cfgAddr7` is acknowledged (SDA low while SCL is high in the ninth clock). `matchMode` then becomes 1 and `readDir` takes bit 0 of the byte (1 = read).
- R3: An address byte that matches nothing is not acknowledged and `matchMode` stays 0. Every later byte is neither acknowledged nor reported until the next START or STOP.
- R4: With `cfgGcEn` = 1, the byte 0x00 is acknowledged with `matchMode` = 2 and `readDir` = 0. The byte 0x01 is not acknowledged. With `cfgGcEn` = 0, the byte 0x00 is not acknowledged.
- R5: With `cfgTenEn` = 1, a write header (bits 7..3 = 11110, bits 2..1 = `cfgAddr10[9:8]`, bit 0 = 0) is acknowledged. A following byte equal to `cfgAddr10[7:0]` is then acknowledged with `matchMode` = 3 and `readDir` = 0. If the second byte differs, it is not acknowledged.
- R6: A read header (same layout with bit 0 = 1) is acknowledged, with `matchMode` = 3 and `readDir` = 1, only after a repeated START that follows a matched 10-bit write. After a STOP, a read header is not acknowledged.
- R7: In a matched write, each data byte appears on `rxData` with a one-cycle `rxValid` pulse after the eighth rising SCL edge, and is acknowledged.
- R8: In a matched read, `txData` is taken (one-cycle `txTaken` pulse) at the ninth rising edge of the address byte. It is shifted out MSB first, with `sdaOe` equal to the inverse of each bit.
- R9: If the host acknowledges a read byte (SDA low at the ninth rising edge), the next `txData` is taken. If the host does not acknowledge, no further byte is taken and `sdaOe` stays 0 until the next START or STOP.
- R10: A STOP clears `matchMode` and `sdaOe` and forgets a matched 10-bit write. A START in the middle of a byte clears `matchMode` and restarts address reception.
- R11: A repeated START after a matched 7-bit write, followed by the same address with bit 0 = 1, gives `readDir` = 1 and starts transmitting.
- R12: `sdaOe` changes only in the cycle after a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| cfgAddr7 | input | 7 | Own 7-bit address |
| cfgAddr10 | input | 10 | Own 10-bit address |
| cfgTenEn | input | 1 | Enables 10-bit address matching |
| cfgGcEn | input | 1 | Enables general-call matching |
| txData | input | 8 | Byte to transmit in read transfers |
| sdaOe | output | 1 | 1 pulls SDA low |
| matchMode | output | 2 | 0 none, 1 7-bit, 2 general call, 3 10-bit |
| readDir | output | 1 | Direction of the current transfer, 1 = read |
| rxData | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle strobe for a new `rxData` |
| txTaken | output | 1 | One-cycle strobe: `txData` was taken |

## Verification
The hardest state to reach is the 10-bit read. It needs a header write, a matching second byte and a repeated START with the read header, all without a STOP, because a STOP erases the earlier match. The bench drives the whole sequence as a bus host and then checks that the same read header is refused after a STOP. A START in the middle of a byte is produced by cutting a data byte off after three bits. A host NACK is produced by a read in which the host withholds the acknowledge and then clocks one more byte, which must read back as all ones.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int A7_W   = BYTE_W - 1;
  localparam int A10_W  = BYTE_W + 2;
  localparam logic [4:0] HDR10 = 5'b11110;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_A7   = 2'd1,
    MODE_GC   = 2'd2,
    MODE_A10  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR1, ST_ADDR2, ST_RX, ST_TX, ST_SKIP
  } state_e;

  typedef struct packed {
    logic ackSet;
    logic loadTx;
    logic txStop;
  } ctl_s;
endpackage

// File: rtl/i2c_am_dp.sv
module i2c_am_dp
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctl_s              ctl,
  input  logic [BYTE_W-1:0] txData,
  output logic              evStart,
  output logic              evStop,
  output logic              evFall,
  output logic              byteDone,
  output logic              ackRise,
  output logic              ackSda,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] rxShift,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);

  logic sclQ, sdaQ, sclP, sdaP;
  logic evRise;
  logic [CNT_W-1:0] bitCnt;
  logic ackNext, txActive;
  logic [BYTE_W-1:0] txSh;

  // input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] sclSync, sdaSync;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclQ = sclSync[SYNC_STAGES-1];
      assign sdaQ = sdaSync[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclQ;
      sdaP <= sdaQ;
    end
  end

  assign evRise  = sclQ & ~sclP;
  assign evFall  = ~sclQ & sclP;
  assign evStart = sclQ & sclP & sdaP & ~sdaQ;
  assign evStop  = sclQ & sclP & ~sdaP & sdaQ;

  assign byteDone = evRise && (bitCnt == CNT_LAST);
  assign ackRise  = evRise && (bitCnt == CNT_ACK);
  assign ackSda   = sdaQ;
  assign rxByte   = {rxShift[BYTE_W-2:0], sdaQ};

  // bit counter and receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (evStart || evStop) begin
      bitCnt <= '0;
    end else if (evRise) begin
      if (bitCnt == CNT_ACK) begin
        bitCnt <= '0;
      end else begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= rxByte;
      end
    end
  end

  // transmit shifter and open-drain control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackNext  <= 1'b0;
      txActive <= 1'b0;
      txSh     <= '0;
      sdaOe    <= 1'b0;
    end else if (evStart || evStop) begin
      ackNext  <= 1'b0;
      txActive <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      if (ctl.ackSet)      ackNext <= 1'b1;
      else if (ackRise)    ackNext <= 1'b0;

      if (ctl.loadTx)      txActive <= 1'b1;
      else if (ctl.txStop) txActive <= 1'b0;

      if (ctl.loadTx) begin
        txSh <= txData;
      end else if (evFall && txActive && (bitCnt < CNT_ACK)) begin
        txSh <= {txSh[BYTE_W-2:0], 1'b1};
      end

      if (evFall) begin
        if (bitCnt == CNT_ACK)  sdaOe <= ackNext;
        else if (txActive)      sdaOe <= ~txSh[BYTE_W-1];
        else                    sdaOe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_am_ctl.sv
module i2c_am_ctl
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              byteDone,
  input  logic              ackRise,
  input  logic              ackSda,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [A7_W-1:0]   cfgAddr7,
  input  logic [A10_W-1:0]  cfgAddr10,
  input  logic              cfgTenEn,
  input  logic              cfgGcEn,
  output ctl_s              ctl,
  output mode_e             matchMode,
  output logic              readDir,
  output logic              rxValid,
  output logic              txTaken
);
  state_e state, nxtState, pendSt, nxtPend;
  mode_e  nxtMode;
  logic   nxtDir, tenOk, nxtTen, rxPulse;
  logic   hdrHit;

  assign hdrHit = cfgTenEn && (rxByte[BYTE_W-1:3] == HDR10) &&
                  (rxByte[2:1] == cfgAddr10[A10_W-1:BYTE_W]);

  always_comb begin
    nxtState   = state;
    nxtPend    = pendSt;
    nxtMode    = matchMode;
    nxtDir     = readDir;
    nxtTen     = tenOk;
    rxPulse    = 1'b0;
    ctl        = '0;

    if (byteDone) begin
      case (state)
        ST_ADDR1: begin
          nxtTen  = 1'b0;
          nxtPend = ST_SKIP;
          if (rxByte[BYTE_W-1:1] == cfgAddr7) begin
            ctl.ackSet = 1'b1;
            nxtMode    = MODE_A7;
            nxtDir     = rxByte[0];
            nxtPend    = rxByte[0] ? ST_TX : ST_RX;
          end else if (cfgGcEn && (rxByte == '0)) begin
            ctl.ackSet = 1'b1;
            nxtMode    = MODE_GC;
            nxtDir     = 1'b0;
            nxtPend    = ST_RX;
          end else if (hdrHit && !rxByte[0]) begin
            ctl.ackSet = 1'b1;
            nxtDir     = 1'b0;
            nxtPend    = ST_ADDR2;
          end else if (hdrHit && rxByte[0] && tenOk) begin
            ctl.ackSet = 1'b1;
            nxtMode    = MODE_A10;
            nxtDir     = 1'b1;
            nxtTen     = 1'b1;
            nxtPend    = ST_TX;
          end
        end
        ST_ADDR2: begin
          if (rxByte == cfgAddr10[BYTE_W-1:0]) begin
            ctl.ackSet = 1'b1;
            nxtMode    = MODE_A10;
            nxtTen     = 1'b1;
            nxtPend    = ST_RX;
          end else begin
            nxtTen  = 1'b0;
            nxtPend = ST_SKIP;
          end
        end
        ST_RX: begin
          ctl.ackSet = 1'b1;
          rxPulse    = 1'b1;
          nxtPend    = ST_RX;
        end
        default: ;
      endcase
    end

    if (ackRise) begin
      if (state == ST_TX) begin
        if (!ackSda) begin
          ctl.loadTx = 1'b1;
        end else begin
          ctl.txStop = 1'b1;
          nxtState   = ST_SKIP;
        end
      end else if (state == ST_ADDR1 || state == ST_ADDR2 || state == ST_RX) begin
        nxtState   = pendSt;
        ctl.loadTx = (pendSt == ST_TX);
      end
    end

    if (evStart) begin
      nxtState = ST_ADDR1;
      nxtMode  = MODE_NONE;
      nxtDir   = 1'b0;
      ctl      = '0;
      rxPulse  = 1'b0;
    end else if (evStop) begin
      nxtState = ST_IDLE;
      nxtMode  = MODE_NONE;
      nxtDir   = 1'b0;
      nxtTen   = 1'b0;
      ctl      = '0;
      rxPulse  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendSt    <= ST_SKIP;
      matchMode <= MODE_NONE;
      readDir   <= 1'b0;
      tenOk     <= 1'b0;
      rxValid   <= 1'b0;
      txTaken   <= 1'b0;
    end else begin
      state     <= nxtState;
      pendSt    <= nxtPend;
      matchMode <= nxtMode;
      readDir   <= nxtDir;
      tenOk     <= nxtTen;
      rxValid   <= rxPulse;
      txTaken   <= ctl.loadTx;
    end
  end
endmodule

// File: rtl/i2c_am_top.sv
module i2c_am_top
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [A7_W-1:0]   cfgAddr7,
  input  logic [A10_W-1:0]  cfgAddr10,
  input  logic              cfgTenEn,
  input  logic              cfgGcEn,
  input  logic [BYTE_W-1:0] txData,
  output logic              sdaOe,
  output logic [1:0]        matchMode,
  output logic              readDir,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              txTaken
);
  ctl_s              ctl;
  logic              evStart, evStop, evFall, byteDone, ackRise, ackSda;
  logic [BYTE_W-1:0] rxByte;
  mode_e             modeQ;

  i2c_am_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk, .rstN, .sclIn, .sdaIn, .ctl, .txData,
    .evStart, .evStop, .evFall, .byteDone, .ackRise, .ackSda,
    .rxByte, .rxShift(rxData), .sdaOe
  );

  i2c_am_ctl ctl_i (
    .clk, .rstN, .evStart, .evStop, .byteDone, .ackRise, .ackSda,
    .rxByte, .cfgAddr7, .cfgAddr10, .cfgTenEn, .cfgGcEn,
    .ctl, .matchMode(modeQ), .readDir, .rxValid, .txTaken
  );

  assign matchMode = modeQ;
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic [1:0] matchMode,
  input logic       readDir,
  input logic       rxValid,
  input logic       txTaken,
  input logic       evFall,
  input logic       evStart,
  input logic       evStop
);
  a_r12_oe_moves_on_event: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(evFall || evStart || evStop));

  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (matchMode == 2'd0) && !sdaOe);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    evStart |=> (matchMode == 2'd0) && !readDir && !sdaOe);

  a_r7_rx_needs_write_match: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (matchMode != 2'd0) && !readDir);

  a_r8_tx_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    txTaken |-> readDir && (matchMode != 2'd0));

  a_r4_gc_is_write: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode == 2'd2) |-> !readDir);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, txTaken}));
endmodule

bind i2c_am_top i2c_am_chk chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .matchMode(matchMode),
  .readDir(readDir), .rxValid(rxValid), .txTaken(txTaken),
  .evFall(evFall), .evStart(evStart), .evStop(evStop)
);

// File: tb/i2c_am_top_tb_top.sv
module i2c_am_top_tb_top;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaLine;
  logic [6:0] cfgAddr7 = 7'h2A;
  logic [9:0] cfgAddr10 = 10'h2B5;
  logic       cfgTenEn = 1'b0;
  logic       cfgGcEn = 1'b0;
  logic [7:0] txData;
  logic       sdaOe, readDir, rxValid, txTaken;
  logic [1:0] matchMode;
  logic [7:0] rxData;

  int nChk = 0;
  int nBad = 0;
  int txCnt = 0;
  logic [7:0] expQ[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  function automatic logic [7:0] txVal(input int n);
    return 8'hC3 ^ 8'(n * 37);
  endfunction

  assign txData = txVal(txCnt);

  i2c_am_top dut_i (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaLine), .cfgAddr7, .cfgAddr10,
    .cfgTenEn, .cfgGcEn, .txData, .sdaOe, .matchMode, .readDir,
    .rxData, .rxValid, .txTaken
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (expQ.size() == 0) chk("R3 R7 unexpected rxValid", int'(rxData), -1);
      else chk("R7 rxData", int'(rxData), int'(expQ.pop_front()));
    end
    if (rstN && txTaken) txCnt++;
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    sdaM = b; waitN(H); sclM = 1'b1; waitN(H); sclM = 1'b0; waitN(3);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sdaM = 1'b1; waitN(H); sclM = 1'b1; waitN(H / 2);
    acked = ~sdaLine;
    waitN(H / 2); sclM = 1'b0; waitN(3);
  endtask

  task automatic readByte(input logic hostAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitN(H); sclM = 1'b1; waitN(H / 2);
      v[i] = sdaLine;
      waitN(H / 2); sclM = 1'b0; waitN(3);
    end
    sdaM = ~hostAck; waitN(H); sclM = 1'b1; waitN(H); sclM = 1'b0; waitN(3);
    sdaM = 1'b1;
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitN(H); sdaM = 1'b0; waitN(H); sclM = 1'b0; waitN(3);
  endtask

  task automatic rstartCond();
    sdaM = 1'b1; waitN(H); sclM = 1'b1; waitN(H); sdaM = 1'b0; waitN(H);
    sclM = 1'b0; waitN(3);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitN(H); sclM = 1'b1; waitN(H); sdaM = 1'b1; waitN(H);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    nBad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    logic a;
    logic [7:0] v;
    int base;
    waitN(5);
    // R1 reset state
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 matchMode", matchMode, 0);
    chk("R1 readDir", readDir, 0);
    chk("R1 strobes", {rxValid, txTaken}, 0);
    rstN = 1'b1;
    waitN(5);

    // R2 R7 7-bit write, then R10 stop
    startCond();
    sendByte(8'h54, a);
    chk("R2 ack", a, 1);
    chk("R2 matchMode", matchMode, 1);
    chk("R2 readDir", readDir, 0);
    expQ.push_back(8'hA5); sendByte(8'hA5, a); chk("R7 ack byte0", a, 1);
    expQ.push_back(8'h3C); sendByte(8'h3C, a); chk("R7 ack byte1", a, 1);
    stopCond();
    chk("R10 mode after stop", matchMode, 0);
    chk("R7 queue drained", expQ.size(), 0);

    // R3 mismatch
    startCond();
    sendByte(8'hAA, a);
    chk("R3 no ack", a, 0);
    chk("R3 mode", matchMode, 0);
    sendByte(8'h12, a);
    chk("R3 later byte no ack", a, 0);
    stopCond();

    // R4 general call
    cfgGcEn = 1'b1;
    startCond();
    sendByte(8'h00, a);
    chk("R4 gc ack", a, 1);
    chk("R4 gc mode", matchMode, 2);
    expQ.push_back(8'h77); sendByte(8'h77, a); chk("R4 gc data ack", a, 1);
    stopCond();
    startCond();
    sendByte(8'h01, a);
    chk("R4 gc read refused", a, 0);
    stopCond();
    cfgGcEn = 1'b0;
    startCond();
    sendByte(8'h00, a);
    chk("R4 gc disabled", a, 0);
    chk("R4 gc disabled mode", matchMode, 0);
    stopCond();

    // R8 R9 7-bit read
    base = txCnt;
    startCond();
    sendByte(8'h55, a);
    chk("R8 read ack", a, 1);
    chk("R8 readDir", readDir, 1);
    chk("R8 first take", txCnt, base + 1);
    readByte(1'b1, v);
    chk("R8 byte0", v, txVal(base));
    chk("R9 take after host ack", txCnt, base + 2);
    readByte(1'b0, v);
    chk("R8 byte1", v, txVal(base + 1));
    chk("R9 released after nack", sdaOe, 0);
    readByte(1'b0, v);
    chk("R9 idle after nack", v, 8'hFF);
    chk("R9 no take after nack", txCnt, base + 2);
    stopCond();

    // R11 write then repeated START read
    startCond();
    sendByte(8'h54, a);
    expQ.push_back(8'h10); sendByte(8'h10, a);
    rstartCond();
    base = txCnt;
    sendByte(8'h55, a);
    chk("R11 read ack", a, 1);
    chk("R11 readDir", readDir, 1);
    readByte(1'b0, v);
    chk("R11 data", v, txVal(base));
    stopCond();

    // R5 R6 10-bit write then read
    cfgTenEn = 1'b1;
    startCond();
    sendByte(8'hF4, a);
    chk("R5 header ack", a, 1);
    sendByte(8'hB5, a);
    chk("R5 second ack", a, 1);
    chk("R5 mode", matchMode, 3);
    expQ.push_back(8'h99); sendByte(8'h99, a);
    rstartCond();
    base = txCnt;
    sendByte(8'hF5, a);
    chk("R6 read header ack", a, 1);
    chk("R6 mode", matchMode, 3);
    chk("R6 readDir", readDir, 1);
    readByte(1'b0, v);
    chk("R6 data", v, txVal(base));
    stopCond();

    // R6 R10 cold read header refused
    startCond();
    sendByte(8'hF5, a);
    chk("R6 cold read refused", a, 0);
    chk("R6 cold mode", matchMode, 0);
    stopCond();

    // R5 wrong second byte
    startCond();
    sendByte(8'hF4, a);
    sendByte(8'hB4, a);
    chk("R5 wrong low byte", a, 0);
    chk("R5 wrong low mode", matchMode, 0);
    stopCond();
    cfgTenEn = 1'b0;

    // R10 START in mid byte
    startCond();
    sendByte(8'h54, a);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    rstartCond();
    chk("R10 mode after mid-byte start", matchMode, 0);
    sendByte(8'h54, a);
    chk("R10 readdress ack", a, 1);
    chk("R10 readdress mode", matchMode, 1);
    stopCond();
    chk("R7 queue final", expQ.size(), 0);
    chk("R12 sdaOe idle", sdaOe, 0);

    finishRun();
  end
endmodule